// File: doc/BRIEF.md
# Destination Address Filter with Multicast Hash

This block decides whether a received frame should be kept, based only on its destination address. The address arrives one byte per cycle on a byte stream with a valid strobe, framed by a start pulse and an end pulse. The block compares the stream against a programmed station address. It recognises the all-ones broadcast address. For group addresses it computes a CRC-32 over the address bytes and uses part of the result to pick one bit of a 64-bit filter array.

Each frame produces exactly one decision. When the sixth address byte has been seen, a one-cycle `decValid` pulse follows on the next clock, with `accept` set or cleared. A frame that ends before its sixth byte is rejected one clock after the end pulse. Bytes beyond the sixth have no effect. Bytes outside a frame also have no effect.

Top module: `dst_addr_filter`

## Requirements
- R1: While reset is asserted and after it is released, `decValid` and `accept` are 0 until a frame produces a decision.
- R2: Only the first six bytes taken after `frameStart` are examined. Later bytes of the same frame produce no further decision and do not alter the one already made.
- R3: When the sixth byte of a frame is taken, `decValid` pulses high for one cycle on the next clock edge. Gaps in `byteValid` between bytes are allowed.
- R4: The k-th received byte (k = 0..5) is compared with `physAddr[8k+7:8k]`. An individual address (bit 0 of byte 0 equal to 0) is accepted exactly when all six bytes match. If any single byte differs, the frame is rejected.
- R5: A destination of six 0xFF bytes is broadcast. It is accepted when `bcastEn` is 1 and rejected when it is 0.
- R6: A destination whose byte 0 has bit 0 set and which is not broadcast is multicast. It is accepted when `mcastEn` is 1 and `mcastFilter[h]` is 1, and rejected otherwise. The hash h is computed as follows. Start a 32-bit register at all ones. Process the six bytes in order, each least significant bit first, with the polynomial 0x04C11DB7 in MSB-first form and no final inversion. h is register bits [31:26], with bit 31 as the most significant bit of h.
- R7: If `frameEnd` arrives before the sixth byte, `decValid` pulses one clock later with `accept` 0. If `frameEnd` coincides with the sixth byte, the normal address decision is given instead.
- R8: `accept` is 0 in every cycle in which `decValid` is 0.
- R9: A byte presented together with `frameStart` is taken as byte 0 of the new frame.
- R10: Bytes presented after `frameEnd` and before the next `frameStart` are ignored and produce no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Pulse opening a new frame |
| frameEnd | input | 1 | Pulse closing the current frame |
| byteValid | input | 1 | `byteData` holds a received byte this cycle |
| byteData | input | 8 | Received byte |
| physAddr | input | 48 | Station address; byte k in bits [8k+7:8k] |
| mcastFilter | input | 64 | Multicast filter bit array indexed by hash |
| bcastEn | input | 1 | Allow broadcast frames |
| mcastEn | input | 1 | Allow hashed multicast frames |
| decValid | output | 1 | One-cycle pulse marking a decision |
| accept | output | 1 | Decision: 1 keeps the frame |

## Verification
Two functions can fall in the same cycle. One is the end-of-frame path, which rejects short frames. The other is the sixth-byte path, which gives the address decision. The bench drives `frameEnd` together with the sixth byte and expects a single decision that follows the address rules, not a short-frame reject. It also drives `frameStart` together with the first byte, so that opening a frame and taking a byte happen at once. A scoreboard holds, for every frame, the expected accept value and the exact cycle of the pulse. Any unexpected, missing or late pulse is reported.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int IDX_W = $clog2(ADDR_BYTES + 1);

  typedef struct packed {
    logic             clearAcc;
    logic             loadByte;
    logic [IDX_W-1:0] byteIdx;
    logic             finalize;
    logic             shortEnd;
  } ctrlStrobes_t;
endpackage

// File: rtl/daf_crc_byte.sv
module daf_crc_byte #(
  parameter int unsigned CRC_W = 32,
  parameter logic [CRC_W-1:0] POLY_REFL = 32'hEDB88320
) (
  input  logic [CRC_W-1:0] crcIn,
  input  logic [7:0]       dataIn,
  output logic [CRC_W-1:0] crcOut
);
  // reflected register: bit 0 is the oldest position, data enters LSB first
  logic [CRC_W-1:0] stage [0:8];
  assign stage[0] = crcIn;

  for (genvar g = 0; g < 8; g++) begin : g_bit
    assign stage[g+1] = (stage[g][0] ^ dataIn[g]) ? ((stage[g] >> 1) ^ POLY_REFL)
                                                  : (stage[g] >> 1);
  end

  assign crcOut = stage[8];
endmodule

// File: rtl/daf_ctrl.sv
module daf_ctrl
  import daf_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameStart,
  input  logic         frameEnd,
  input  logic         byteValid,
  output ctrlStrobes_t strb
);
  logic [IDX_W-1:0] cnt;
  logic             active;
  logic             decided;

  logic [IDX_W-1:0] cntEff;
  logic             activeEff;
  logic             decidedEff;
  logic             take;
  logic             lastByte;
  logic             endShort;

  always_comb begin
    activeEff  = frameStart | active;
    cntEff     = frameStart ? '0 : cnt;
    decidedEff = frameStart ? 1'b0 : decided;
    take       = byteValid & activeEff & (cntEff < IDX_W'(ADDR_BYTES));
    lastByte   = take & (cntEff == IDX_W'(ADDR_BYTES - 1));
    endShort   = frameEnd & activeEff & ~decidedEff & ~lastByte;

    strb.clearAcc = frameStart;
    strb.loadByte = take;
    strb.byteIdx  = cntEff;
    strb.finalize = lastByte;
    strb.shortEnd = endShort;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      active  <= 1'b0;
      decided <= 1'b0;
    end else begin
      cnt     <= cntEff + {{(IDX_W-1){1'b0}}, take};
      decided <= decidedEff | lastByte | endShort;
      active  <= frameEnd ? 1'b0 : activeEff;
    end
  end
endmodule

// File: rtl/daf_datapath.sv
module daf_datapath
  import daf_pkg::*;
#(
  parameter int unsigned HASH_BITS = 6,
  parameter logic [31:0] CRC_POLY  = 32'hEDB88320,
  localparam int unsigned FILTER_BITS = 1 << HASH_BITS
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobes_t              strb,
  input  logic [7:0]                byteData,
  input  logic [8*ADDR_BYTES-1:0]   physAddr,
  input  logic [FILTER_BITS-1:0]    mcastFilter,
  input  logic                      bcastEn,
  input  logic                      mcastEn,
  output logic                      decValid,
  output logic                      accept
);
  logic [31:0] crcAcc, crcBase, crcStep, crcNew;
  logic        mismatch, misBase, misNew;
  logic        allOnes, onesBase, onesNew;
  logic        groupBit, groupBase, groupNew;
  logic [7:0]  physByte;
  logic [HASH_BITS-1:0] hashIdx;
  logic        unicastHit, bcastHit, mcastHit;

  daf_crc_byte #(.CRC_W(32), .POLY_REFL(CRC_POLY)) u_crc (
    .crcIn (crcBase),
    .dataIn(byteData),
    .crcOut(crcStep)
  );

  always_comb begin
    physByte = '0;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (strb.byteIdx == IDX_W'(i)) physByte = physAddr[8*i +: 8];
    end
  end

  always_comb begin
    crcBase   = strb.clearAcc ? '1   : crcAcc;
    misBase   = strb.clearAcc ? 1'b0 : mismatch;
    onesBase  = strb.clearAcc ? 1'b1 : allOnes;
    groupBase = strb.clearAcc ? 1'b0 : groupBit;

    crcNew   = strb.loadByte ? crcStep : crcBase;
    misNew   = misBase  | (strb.loadByte & (byteData != physByte));
    onesNew  = onesBase & (~strb.loadByte | (byteData == 8'hFF));
    groupNew = (strb.loadByte && strb.byteIdx == '0) ? byteData[0] : groupBase;
  end

  // hash = top bits of the MSB-first register = low bits of the reflected one, reversed
  for (genvar k = 0; k < HASH_BITS; k++) begin : g_hash
    assign hashIdx[k] = crcNew[HASH_BITS-1-k];
  end

  always_comb begin
    unicastHit = ~groupNew & ~misNew;
    bcastHit   = onesNew & bcastEn;
    mcastHit   = groupNew & ~onesNew & mcastEn & mcastFilter[hashIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcAcc   <= '1;
      mismatch <= 1'b0;
      allOnes  <= 1'b1;
      groupBit <= 1'b0;
      decValid <= 1'b0;
      accept   <= 1'b0;
    end else begin
      crcAcc   <= crcNew;
      mismatch <= misNew;
      allOnes  <= onesNew;
      groupBit <= groupNew;
      decValid <= strb.finalize | strb.shortEnd;
      accept   <= strb.finalize & (unicastHit | bcastHit | mcastHit);
    end
  end
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
  import daf_pkg::*;
#(
  parameter int unsigned HASH_BITS = 6,
  parameter logic [31:0] CRC_POLY  = 32'hEDB88320
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          frameStart,
  input  logic                          frameEnd,
  input  logic                          byteValid,
  input  logic [7:0]                    byteData,
  input  logic [8*ADDR_BYTES-1:0]       physAddr,
  input  logic [(1 << HASH_BITS)-1:0]   mcastFilter,
  input  logic                          bcastEn,
  input  logic                          mcastEn,
  output logic                          decValid,
  output logic                          accept
);
  ctrlStrobes_t strb;

  daf_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameStart(frameStart),
    .frameEnd  (frameEnd),
    .byteValid (byteValid),
    .strb      (strb)
  );

  daf_datapath #(.HASH_BITS(HASH_BITS), .CRC_POLY(CRC_POLY)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .byteData   (byteData),
    .physAddr   (physAddr),
    .mcastFilter(mcastFilter),
    .bcastEn    (bcastEn),
    .mcastEn    (mcastEn),
    .decValid   (decValid),
    .accept     (accept)
  );
endmodule

// File: rtl/daf_checker.sv
module daf_checker
  import daf_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       frameStart,
  input logic       frameEnd,
  input logic       byteValid,
  input logic [7:0] byteData,
  input logic       bcastEn,
  input logic       mcastEn,
  input logic       decValid,
  input logic       accept
);
  logic [IDX_W-1:0] ckCnt;
  logic             ckActive, ckOnes, ckGroup;
  logic [IDX_W-1:0] ckCntEff;
  logic             ckActEff, ckOnesEff, ckTake, ckSixth, ckShort, ckOnesAfter;

  always_comb begin
    ckActEff    = frameStart | ckActive;
    ckCntEff    = frameStart ? '0 : ckCnt;
    ckOnesEff   = frameStart | ckOnes;
    ckTake      = byteValid & ckActEff & (ckCntEff < IDX_W'(ADDR_BYTES));
    ckSixth     = ckTake & (ckCntEff == IDX_W'(ADDR_BYTES - 1));
    ckOnesAfter = ckOnesEff & (byteData == 8'hFF);
    ckShort     = frameEnd & ckActEff & ~ckSixth & (ckCntEff < IDX_W'(ADDR_BYTES));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckCnt    <= '0;
      ckActive <= 1'b0;
      ckOnes   <= 1'b1;
      ckGroup  <= 1'b0;
    end else begin
      ckCnt    <= ckCntEff + {{(IDX_W-1){1'b0}}, ckTake};
      ckActive <= frameEnd ? 1'b0 : ckActEff;
      ckOnes   <= ckTake ? ckOnesAfter : ckOnesEff;
      if (ckTake && ckCntEff == '0) ckGroup <= byteData[0];
    end
  end

  p_accept_qualified_r8: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> decValid);

  p_sixth_decides_r3: assert property (@(posedge clk) disable iff (!rstN)
    ckSixth |=> decValid);

  p_short_reject_r7: assert property (@(posedge clk) disable iff (!rstN)
    ckShort |=> (decValid && !accept));

  p_bcast_enabled_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ckSixth && ckOnesAfter && bcastEn) |=> accept);

  p_mcast_disabled_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ckSixth && ckGroup && !ckOnesAfter && !mcastEn) |=> !accept);

  p_no_decision_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!ckActEff) |=> !decValid);
endmodule

bind dst_addr_filter daf_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .frameStart(frameStart),
  .frameEnd  (frameEnd),
  .byteValid (byteValid),
  .byteData  (byteData),
  .bcastEn   (bcastEn),
  .mcastEn   (mcastEn),
  .decValid  (decValid),
  .accept    (accept)
);

// File: tb/dst_addr_filter_tb.sv
module dst_addr_filter_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        frameStart, frameEnd, byteValid;
  logic [7:0]  byteData;
  logic [47:0] phys;
  logic [63:0] filt;
  logic        bEn, mEn;
  logic        decValid, accept;

  int     errors = 0;
  int     checks = 0;
  longint cyc = 0;
  bit     done = 1'b0;

  typedef struct {
    bit     acc;
    longint when;
    string  tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dst_addr_filter u_dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameEnd(frameEnd),
    .byteValid(byteValid), .byteData(byteData), .physAddr(phys),
    .mcastFilter(filt), .bcastEn(bEn), .mcastEn(mEn),
    .decValid(decValid), .accept(accept)
  );

  function automatic logic [5:0] hashOf(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic fb;
        fb = c[31] ^ a[8*i + j];
        c  = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    end
    return c[31:26];
  endfunction

  function automatic bit expAcc(input logic [47:0] a);
    if (!a[0]) return (a == phys);
    if (&a)    return bEn;
    return mEn && filt[hashOf(a)];
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // monitor: pops the scoreboard on each decision
  always @(negedge clk) begin
    if (rstN) begin
      if (accept && !decValid) check(1'b0, "R8", "accept without decValid", 1, 0);
      if (decValid) begin
        if (q.size() == 0) begin
          check(1'b0, "R2", "unexpected decision", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(accept == e.acc, e.tag, "accept value", accept, e.acc);
          check(cyc == e.when, "R3", "decision cycle", cyc, e.when);
        end
      end
    end
  end

  task automatic idle();
    frameStart = 1'b0; frameEnd = 1'b0; byteValid = 1'b0; byteData = 8'h00;
  endtask

  function automatic logic [7:0] byteOf(input logic [47:0] a, input int i);
    return (i < 6) ? a[8*i +: 8] : (8'h3C ^ 8'(i));
  endfunction

  task automatic putByte(input logic [47:0] a, input int i, input int total,
                         input bit endOnLast, input string tag);
    byteValid = 1'b1;
    byteData  = byteOf(a, i);
    if (i == 5) q.push_back('{expAcc(a), cyc + 1, tag});
    if (endOnLast && i == total - 1) begin
      frameEnd = 1'b1;
      if (total < 6) q.push_back('{1'b0, cyc + 1, tag});
    end
  endtask

  task automatic runFrame(input logic [47:0] a, input int total, input bit endOnLast,
                          input bit combStart, input int gap, input string tag);
    int i = 0;
    @(negedge clk); idle(); frameStart = 1'b1;
    if (combStart && total > 0) begin
      putByte(a, 0, total, endOnLast, tag);
      i = 1;
    end
    while (i < total) begin
      for (int g = 0; g < gap; g++) begin @(negedge clk); idle(); end
      @(negedge clk); idle();
      putByte(a, i, total, endOnLast, tag);
      i++;
    end
    if (!(endOnLast && total > 0)) begin
      @(negedge clk); idle(); frameEnd = 1'b1;
      if (total < 6) q.push_back('{1'b0, cyc + 1, tag});
    end
    @(negedge clk); idle();
    @(negedge clk);
  endtask

  localparam logic [47:0] UNI   = 48'h9A78_5634_1202;
  localparam logic [47:0] MC    = 48'h0000_005E_0001;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

  initial begin
    idle();
    phys = UNI; filt = '0; bEn = 1'b1; mEn = 1'b1;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(decValid == 1'b0 && accept == 1'b0, "R1", "outputs in reset",
          {decValid, accept}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(decValid == 1'b0 && accept == 1'b0, "R1", "outputs after reset",
          {decValid, accept}, 0);

    runFrame(UNI, 6, 1'b0, 1'b0, 0, "R4");                 // exact match
    runFrame(UNI ^ 48'h0100_0000_0000, 6, 1'b0, 1'b0, 0, "R4"); // last byte differs
    runFrame(UNI ^ 48'h0000_0000_0004, 6, 1'b0, 1'b0, 0, "R4"); // first byte differs
    runFrame(UNI, 6, 1'b0, 1'b0, 2, "R3");                 // gaps between bytes
    runFrame(UNI, 6, 1'b0, 1'b1, 0, "R9");                 // byte with frameStart
    runFrame(UNI, 10, 1'b0, 1'b0, 0, "R2");                // trailing bytes
    runFrame(BCAST, 6, 1'b0, 1'b0, 0, "R5");
    bEn = 1'b0;
    runFrame(BCAST, 6, 1'b0, 1'b0, 0, "R5");
    bEn = 1'b1;
    filt = '1;
    runFrame(MC, 6, 1'b0, 1'b0, 0, "R6");
    mEn = 1'b0;
    runFrame(MC, 6, 1'b0, 1'b0, 0, "R6");
    mEn = 1'b1;
    filt = 64'd1 << hashOf(MC);
    runFrame(MC, 6, 1'b0, 1'b0, 1, "R6");
    filt = ~(64'd1 << hashOf(MC));
    runFrame(MC, 6, 1'b0, 1'b0, 0, "R6");
    filt = '0;
    runFrame(UNI, 3, 1'b0, 1'b0, 0, "R7");                 // short frame
    runFrame(UNI, 0, 1'b0, 1'b0, 0, "R7");                 // empty frame
    runFrame(UNI, 5, 1'b1, 1'b0, 0, "R7");                 // end with fifth byte
    runFrame(UNI, 6, 1'b1, 1'b0, 0, "R7");                 // end with sixth byte

    // stray bytes outside any frame
    begin
      int seen = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk); idle();
        if (decValid) seen++;
        byteValid = 1'b1; byteData = byteOf(UNI, i);
      end
      for (int i = 0; i < 3; i++) begin
        @(negedge clk); idle();
        if (decValid) seen++;
      end
      check(seen == 0, "R10", "decisions from stray bytes", seen, 0);
    end

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R3", "missing decisions", q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule